// File: doc/BRIEF.md
# Configurable memory wait-state generator

This block turns a 16-bit wait-control word into per-region access latencies and stalls each bus access for the computed number of cycles. It serves three cartridge ROM windows, one cartridge SRAM window, one external work RAM region and a set of internal zero-wait regions. The bus starts an access with a one-cycle `acc_start` pulse and gives the region number, the width, the sequential flag, the fetch flag and the direction. The block latches the total cost and raises `acc_ready` in the last cycle of the access.

A cartridge 32-bit access is built from two 16-bit halves. A non-sequential one pays the first-access wait, one extra cycle and the sequential wait. A sequential one pays twice the sequential wait plus one. When the prefetch bit is set, instruction fetches from the ROM windows add no wait. Data accesses still pay in full. A separate combinational port gives the cycle cost of an n-word 32-bit burst to any region, so a transfer engine can plan ahead. The data path is not part of this block.

Top module: `waitstate_gen`

## Requirements
- R1: After reset the control word is 0x0000 and `acc_ready` is low. All latencies therefore equal the decode of 0x0000.
- R2: A load costs 2 plus its wait cycles and a store (`acc_store`=1) costs 1 plus its wait cycles. `acc_ready` is high in cycle number cost, counting the cycle in which `acc_start` is sampled as cycle 1.
- R3: The 2-bit first-access codes map 0,1,2,3 to 4,3,2,8 wait cycles. Window 0 (regions 8,9) takes its code from bits 3:2, window 1 (regions 10,11) from bits 6:5 and window 2 (regions 12,13) from bits 9:8. These codes set the 16-bit non-sequential wait (`acc_seq`=0).
- R4: The sequential bit sets the 16-bit sequential wait (`acc_seq`=1). Bit 4 gives window 0 a wait of 1 when set and 2 when clear. Bit 7 gives window 1 a wait of 1 when set and 4 when clear. Bit 10 gives window 2 a wait of 1 when set and 8 when clear.
- R5: For a cartridge window, a 32-bit access (`acc_wide`=1) waits 2·seq16+1 when sequential and nonseq16+1+seq16 when not. No wait exceeds 17.
- R6: Regions 14 and 15 are SRAM. Their wait is the bits 1:0 code, mapped as in R3, for 16-bit accesses and twice that plus 1 for 32-bit accesses. The sequential flag has no effect on them.
- R7: When bit 14 is set, a fetch (`acc_fetch`=1) from regions 8–13 has zero wait. Data accesses and SRAM fetches keep their full wait.
- R8: Region 2 waits 2 cycles for a 16-bit access and 5 for a 32-bit one. Regions 0,1 and 3–7 wait 0.
- R9: While an access is in progress, `acc_start` is ignored. That access keeps the count it latched, even if the control word is written meanwhile.
- R10: A control write applies to accesses whose start is sampled on a later edge. An access started on the same edge uses the old word.
- R11: `burst_cost` = (1+nonseq32)+(len−1)·(1+seq32) for `burst_region`, using data waits with prefetch ignored. It is 0 when `burst_len` is 0.
- R12: `acc_ready` is a single-cycle pulse, once per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_data | input | 16 | New control word |
| acc_start | input | 1 | Starts an access (ignored while busy) |
| acc_region | input | 4 | Region number of the access |
| acc_wide | input | 1 | 1 = 32-bit, 0 = 16-bit |
| acc_seq | input | 1 | 1 = sequential access |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_ready | output | 1 | High in the final cycle of an access |
| burst_region | input | 4 | Region of a planned burst |
| burst_len | input | BURST_W (8) | Number of 32-bit words in the burst |
| burst_cost | output | COST_W (14) | Total cycles of the burst |

## Verification
Assertions check on every cycle that the control register changes only on a write and then takes the written value. They also check that the stall counter steps down by one while busy, that a ready pulse never lasts two cycles, that the block is idle after reset, and that no selected wait exceeds 17. Only the bench scenarios can show the latency values themselves. These cover the field positions and code tables, the prefetch exemption, the SRAM and work RAM latencies, the burst formula, and which control word an access uses when a write lands on its start edge or during the access. A behavioural model runs beside the design and compares `acc_ready` on every clock.

// File: rtl/ws_pkg.sv
// Package: shared widths, region numbers and latency tables for the
// wait-state generator. Assumes at most four cartridge windows.
package ws_pkg;
    parameter int WAIT_W     = 5;
    parameter int NUM_WIN    = 3;
    parameter int MAX_WAIT   = 17;
    parameter int WRAM_REGION = 2;
    parameter int WRAM_W16   = 2;
    parameter int WRAM_W32   = 5;

    typedef struct packed {
        logic [WAIT_W-1:0] ns16;
        logic [WAIT_W-1:0] s16;
    } win_lat_t;

    typedef struct packed {
        win_lat_t [NUM_WIN-1:0] win;
        logic [WAIT_W-1:0]      sram;
        logic                   pf;
    } lat_tab_t;

    // First-access code to wait cycles.
    function automatic logic [WAIT_W-1:0] first_map(input logic [1:0] code);
        case (code)
            2'd0: first_map = WAIT_W'(4);
            2'd1: first_map = WAIT_W'(3);
            2'd2: first_map = WAIT_W'(2);
            default: first_map = WAIT_W'(8);
        endcase
    endfunction

    // Sequential bit to wait cycles; the slow value doubles per window.
    function automatic logic [WAIT_W-1:0] seq_map(input int w, input logic b);
        seq_map = b ? WAIT_W'(1) : WAIT_W'(2 << w);
    endfunction
endpackage

// File: rtl/ws_cfg_decode.sv
// Holds the control word and decodes it into per-window latencies.
// Assumes field positions: window w code at bits 2+3w+:2, its sequential
// bit at 4+3w, SRAM code at 1:0, prefetch enable at bit 14.
module ws_cfg_decode
    import ws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] data,
    output lat_tab_t    tab
);
    logic [15:0] cfg_q;

    // Control register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= data;
    end

    // One decoder per cartridge window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign tab.win[w].ns16 = first_map(cfg_q[2+3*w +: 2]);
        assign tab.win[w].s16  = seq_map(w, cfg_q[4+3*w]);
    end
    assign tab.sram = first_map(cfg_q[1:0]);
    assign tab.pf   = cfg_q[14];

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg_q == $past(data));
endmodule

// File: rtl/ws_lat_select.sv
// Picks the wait cycles for one access from the decoded tables.
// Assumes regions 8..13 are windows (two per window), 14..15 SRAM.
module ws_lat_select
    import ws_pkg::*;
(
    input  lat_tab_t          tab,
    input  logic [3:0]        region,
    input  logic              wide,
    input  logic              seq,
    input  logic              fetch,
    output logic [WAIT_W-1:0] wait_o
);
    win_lat_t wl;

    // Region decode and 32-bit synthesis from two 16-bit halves.
    always_comb begin
        wl     = tab.win[0];
        wait_o = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (region[2:1] == w[1:0]) wl = tab.win[w];
        if (region == 4'(WRAM_REGION)) begin
            wait_o = wide ? WAIT_W'(WRAM_W32) : WAIT_W'(WRAM_W16);
        end else if (region[3:1] == 3'b111) begin
            wait_o = wide ? {tab.sram[WAIT_W-2:0], 1'b1} : tab.sram;
        end else if (region[3]) begin
            if (tab.pf && fetch)  wait_o = '0;
            else if (wide)        wait_o = seq ? {wl.s16[WAIT_W-2:0], 1'b1}
                                               : wl.ns16 + wl.s16 + WAIT_W'(1);
            else                  wait_o = seq ? wl.s16 : wl.ns16;
        end
    end

    // Bound on any selected wait.
    always_comb begin
        p_wait_bound_r5: assert (wait_o <= WAIT_W'(MAX_WAIT));
    end
endmodule

// File: rtl/ws_stall_counter.sv
// Latches an access cost and counts it down; ready marks the last cycle.
// Assumes cost >= 1. Starts arriving while busy are dropped.
module ws_stall_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cost,
    output logic             ready
);
    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Countdown state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= cost - CNT_W'(1);
        end
    end

    assign ready = busy && (cnt == '0);

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !busy);
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy && cnt == $past(cnt) - CNT_W'(1));
    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
endmodule

// File: rtl/waitstate_gen.sv
// Top: control decode, access latency select, stall counter and burst
// cost. Assumes the bus holds access attributes valid with acc_start.
module waitstate_gen
    import ws_pkg::*;
#(
    parameter int BURST_W = 8,
    localparam int CNT_W  = WAIT_W + 1,
    localparam int COST_W = WAIT_W + 1 + BURST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [15:0]        cfg_data,
    input  logic               acc_start,
    input  logic [3:0]         acc_region,
    input  logic               acc_wide,
    input  logic               acc_seq,
    input  logic               acc_fetch,
    input  logic               acc_store,
    output logic               acc_ready,
    input  logic [3:0]         burst_region,
    input  logic [BURST_W-1:0] burst_len,
    output logic [COST_W-1:0]  burst_cost
);
    lat_tab_t          tab;
    logic [WAIT_W-1:0] acc_wait, b_ns, b_s;
    logic [CNT_W-1:0]  acc_cost;

    ws_cfg_decode u_dec (.clk(clk), .rst_n(rst_n), .we(cfg_we),
                         .data(cfg_data), .tab(tab));

    ws_lat_select u_acc (.tab(tab), .region(acc_region), .wide(acc_wide),
                         .seq(acc_seq), .fetch(acc_fetch), .wait_o(acc_wait));
    ws_lat_select u_bns (.tab(tab), .region(burst_region), .wide(1'b1),
                         .seq(1'b0), .fetch(1'b0), .wait_o(b_ns));
    ws_lat_select u_bs  (.tab(tab), .region(burst_region), .wide(1'b1),
                         .seq(1'b1), .fetch(1'b0), .wait_o(b_s));

    // Access cost: base of 2 for loads, 1 for stores.
    assign acc_cost = CNT_W'(acc_wait) + (acc_store ? CNT_W'(1) : CNT_W'(2));

    ws_stall_counter #(.CNT_W(CNT_W)) u_cnt (.clk(clk), .rst_n(rst_n),
        .start(acc_start), .cost(acc_cost), .ready(acc_ready));

    // Burst cost: one first word then len-1 sequential words.
    always_comb begin
        if (burst_len == '0) burst_cost = '0;
        else burst_cost = COST_W'(b_ns) + COST_W'(1)
                        + COST_W'(burst_len - BURST_W'(1)) * (COST_W'(b_s) + COST_W'(1));
    end
endmodule

// File: tb/waitstate_gen_test.sv
`timescale 1ns/100ps
module waitstate_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_data = '0;
    logic        acc_start = 1'b0;
    logic [3:0]  acc_region = '0;
    logic        acc_wide = 1'b0, acc_seq = 1'b0, acc_fetch = 1'b0, acc_store = 1'b0;
    logic        acc_ready;
    logic [3:0]  burst_region = '0;
    logic [7:0]  burst_len = '0;
    logic [13:0] burst_cost;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    waitstate_gen uut (.*);

    // Behavioural model of the latency rules.
    function automatic int fa(int code);
        case (code & 3) 0: return 4; 1: return 3; 2: return 2; default: return 8; endcase
    endfunction
    function automatic int mwait(int cfg, int rg, bit wide, bit sq, bit ft);
        int w, n16, s16;
        if (rg == 2) return wide ? 5 : 2;
        if (rg >= 14) begin
            s16 = fa(cfg);
            return wide ? 2 * s16 + 1 : s16;
        end
        if (rg >= 8) begin
            w = (rg - 8) / 2;
            n16 = fa(cfg >> (2 + 3 * w));
            s16 = ((cfg >> (4 + 3 * w)) & 1) ? 1 : (2 << w);
            if (ft && ((cfg >> 14) & 1)) return 0;
            if (wide) return sq ? 2 * s16 + 1 : n16 + 1 + s16;
            return sq ? s16 : n16;
        end
        return 0;
    endfunction

    int  mcfg = 0, mrem = 0;
    bit  mbusy = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy = 0; mrem = 0; mcfg = 0;
        end else begin
            if (mbusy) begin
                if (mrem == 0) mbusy = 0; else mrem--;
            end else if (acc_start) begin
                mbusy = 1;
                mrem = mwait(mcfg, acc_region, acc_wide, acc_seq, acc_fetch)
                       + (acc_store ? 1 : 2) - 1;
            end
            if (cfg_we) mcfg = cfg_data;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R12 / R2: ready compared against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(acc_ready == (mbusy && mrem == 0), "R12 ready vs model",
                acc_ready, (mbusy && mrem == 0));
    end

    task automatic access(int rg, bit wide, bit sq, bit ft, bit st, int exp, string tag);
        int n;
        @(negedge clk);
        acc_region = 4'(rg); acc_wide = wide; acc_seq = sq;
        acc_fetch = ft; acc_store = st; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        n = 1;
        while (!acc_ready && n < 100) begin @(negedge clk); n++; end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic wcfg(int v);
        @(negedge clk); cfg_we = 1'b1; cfg_data = 16'(v);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic burst(int rg, int len, int exp, string tag);
        burst_region = 4'(rg); burst_len = 8'(len);
        #1;
        chk(int'(burst_cost) == exp, tag, burst_cost, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(acc_ready == 1'b0, "R1 ready low in reset", acc_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_ready == 1'b0, "R1 ready low after reset", acc_ready, 0);

        // Defaults (R1, R8, R2)
        access(2, 0, 0, 0, 0, 4,  "R8 wram load16");
        access(2, 1, 0, 0, 0, 7,  "R8 wram load32");
        access(2, 0, 0, 0, 1, 3,  "R2 wram store16");
        access(3, 1, 0, 0, 0, 2,  "R8 internal load");
        access(5, 0, 0, 0, 1, 1,  "R2 internal store");
        access(8, 0, 0, 0, 0, 6,  "R1 win0 ns16 default");
        access(10, 0, 1, 0, 0, 6, "R4 win1 seq16 default");
        access(12, 0, 1, 0, 1, 9, "R4 win2 seq16 store default");
        access(9, 1, 1, 0, 0, 7,  "R5 win0 seq32 default");
        access(13, 1, 0, 0, 0, 15, "R5 win2 ns32 default");
        access(8, 0, 0, 1, 0, 6,  "R7 fetch without prefetch");
        access(14, 0, 0, 0, 0, 6, "R6 sram load16 default");

        burst(8, 4, 26, "R11 burst win0 default");
        burst(2, 3, 18, "R11 burst wram");
        burst(3, 5, 5,  "R11 burst internal");
        burst(12, 0, 0, "R11 burst len zero");
        burst(12, 1, 14, "R11 burst single word");

        // New control word 0x42BD (R3, R4, R5, R6, R7)
        wcfg(16'h42BD);
        access(8, 0, 0, 0, 0, 10,  "R3 win0 code3");
        access(9, 0, 1, 0, 0, 3,   "R4 win0 seq bit set");
        access(8, 1, 0, 0, 0, 12,  "R5 win0 ns32");
        access(10, 0, 0, 0, 1, 4,  "R3 win1 code1 store");
        access(11, 1, 1, 0, 0, 5,  "R5 win1 seq32");
        access(12, 0, 0, 0, 0, 4,  "R3 win2 code2");
        access(13, 1, 1, 0, 0, 19, "R4 win2 seq bit clear seq32");
        access(14, 0, 0, 0, 0, 5,  "R6 sram code1");
        access(14, 0, 1, 0, 0, 5,  "R6 sram seq ignored");
        access(15, 1, 0, 0, 1, 8,  "R6 sram mirror store32");
        access(12, 1, 1, 1, 0, 2,  "R7 prefetch fetch zero wait");
        access(12, 1, 1, 0, 0, 19, "R7 prefetch data full wait");
        access(14, 0, 0, 1, 0, 5,  "R7 sram fetch full wait");
        burst(12, 2, 30, "R11 burst ignores prefetch");

        // R9: start and control write during a busy access
        wcfg(0);
        begin
            int n;
            @(negedge clk);
            acc_region = 4'd12; acc_wide = 1; acc_seq = 0; acc_fetch = 0;
            acc_store = 0; acc_start = 1'b1;
            @(negedge clk);
            acc_region = 4'd3; acc_wide = 0;
            cfg_we = 1'b1; cfg_data = 16'h0100;
            @(negedge clk);
            acc_start = 1'b0; cfg_we = 1'b0;
            n = 2;
            while (!acc_ready && n < 100) begin @(negedge clk); n++; end
            chk(n == 15, "R9 busy keeps latched count", n, 15);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(acc_ready == 1'b0, "R9 ignored start gives no ready", acc_ready, 0);
            end
        end
        access(12, 1, 0, 0, 0, 14, "R9 later access uses new word");

        // R10: write on the same edge as a start
        wcfg(0);
        begin
            int n;
            @(negedge clk);
            acc_region = 4'd8; acc_wide = 0; acc_seq = 0; acc_fetch = 0;
            acc_store = 0; acc_start = 1'b1;
            cfg_we = 1'b1; cfg_data = 16'h0004;
            @(negedge clk);
            acc_start = 1'b0; cfg_we = 1'b0;
            n = 1;
            while (!acc_ready && n < 100) begin @(negedge clk); n++; end
            chk(n == 6, "R10 same-edge start uses old word", n, 6);
        end
        access(8, 0, 0, 0, 0, 5, "R10 next access uses new word");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule